// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. Software, or a neighbouring bus block, writes a character into a one-entry holding register. The character then moves into a shift register and is sent as follows: a low start bit, then the data bits least significant first, then an optional parity bit, then one or more high stop bits. The line rests high between frames.

The frame format comes from a line-control byte and is fixed for each character when that character enters the shift register. The control byte sets the character length, the stop length, whether a parity bit is sent and its sense, and a break override. Bit timing comes from an external enable that pulses sixteen times per bit. Two status flags show whether the holding register and the shift register are empty. A character written while another is shifting goes out directly after the current frame's stop bits.

Top module: `async_tx`

## Requirements
- R1: After reset, and whenever nothing is queued or shifting with break off, `txOut` is 1 and both `holdEmpty` and `shiftEmpty` are 1.
- R2: `lineCtl[1:0]` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. A frame is a start bit at 0, followed by that many bits of the character sent least significant bit first.
- R3: Every start, data and parity bit lasts exactly 16 cycles in which `tick16` is 1. Cycles without `tick16` do not advance the frame.
- R4: With `lineCtl[2]`=0 the stop level (1) lasts 16 ticks. With `lineCtl[2]`=1 it lasts 24 ticks for 5-bit characters and 32 ticks for 6-, 7- and 8-bit characters.
- R5: With `lineCtl[3]`=1 a parity bit follows the last data bit. With `lineCtl[3]`=0 no parity bit is sent, and `lineCtl[5:4]` have no effect on the frame.
- R6: With parity on, `lineCtl[4]`=0 makes the count of ones over data and parity odd, and `lineCtl[4]`=1 makes it even. `lineCtl[5]`=1 inverts the parity bit that `lineCtl[4]` would give.
- R7: While `lineCtl[6]` is 1, `txOut` is 0 in that same cycle. Frame timing continues underneath the override.
- R8: `holdEmpty` is 0 from the cycle after a write. It returns to 1 in the cycle after the character moves into the shift register, unless another write lands in that cycle.
- R9: `shiftEmpty` is 0 from the cycle after a character enters the shift register. It is 1 again in the cycle after the last stop tick when nothing is pending. An idle shifter takes a pending character on the next clock.
- R10: A character pending at the last stop tick starts its start bit in the very next cycle, with no idle gap. A write while a character is already pending replaces that pending character.
- R11: Format bits `lineCtl[5:0]` are captured when a character enters the shift register. Changing them mid-frame affects only later characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Baud enable, sixteen pulses per bit time |
| lineCtl | input | 7 | Frame format and break control |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Character to write |
| txOut | output | 1 | Serial output line |
| holdEmpty | output | 1 | Holding register is free |
| shiftEmpty | output | 1 | Shift register idle |

## Verification
A wrong tick count or phase shows on `txOut` as a bit edge that falls on the wrong tick, and the per-cycle model catches it within one bit time. A corrupt shift register or parity snapshot shows as a wrong level inside the frame being sent. Lost or duplicated hand-offs between the two registers show on `holdEmpty` and `shiftEmpty` in the cycle right after the write or the frame end. Cases that stress timing include back-to-back frames, replacing a pending character, changing the format mid-frame, and a tick rate of one per clock.

// File: rtl/tx_pkg.sv
package tx_pkg;

  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_START,
    SEL_DATA,
    SEL_PAR,
    SEL_STOP
  } lineSel_e;

  typedef struct packed {
    logic     loadShift;
    logic     shiftData;
    lineSel_e sel;
  } strobe_t;

  typedef struct packed {
    logic [1:0] lenCode;
    logic       longStop;
    logic       parEn;
  } fmt_t;

endpackage

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick16,
  input  logic    holdFull,
  input  fmt_t    fmt,
  output strobe_t strb,
  output logic    busy
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST    = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_LAST   = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] DOUBLE_LAST = CNT_W'(2 * TICKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] MIN_IDX     = IDX_W'(DATA_W - 4);

  lineSel_e         phase;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitCnt;
  logic [CNT_W-1:0] stopLast;
  logic [CNT_W-1:0] curLast;
  logic [IDX_W-1:0] lastIdx;
  logic             segEnd;
  logic             frameEnd;
  logic             loadShift;

  always_comb begin
    if (!fmt.longStop)           stopLast = BIT_LAST;
    else if (fmt.lenCode == 2'd0) stopLast = HALF_LAST;
    else                          stopLast = DOUBLE_LAST;
  end

  assign curLast   = (phase == SEL_STOP) ? stopLast : BIT_LAST;
  assign lastIdx   = MIN_IDX + IDX_W'(fmt.lenCode);
  assign segEnd    = tick16 && (phase != SEL_IDLE) && (tickCnt == curLast);
  assign frameEnd  = segEnd && (phase == SEL_STOP);
  assign loadShift = holdFull && ((phase == SEL_IDLE) || frameEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= SEL_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (loadShift) begin
      phase   <= SEL_START;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (segEnd) begin
      tickCnt <= '0;
      unique case (phase)
        SEL_START: phase <= SEL_DATA;
        SEL_DATA: begin
          if (bitCnt == lastIdx) phase <= fmt.parEn ? SEL_PAR : SEL_STOP;
          else                   bitCnt <= bitCnt + 1'b1;
        end
        SEL_PAR:  phase <= SEL_STOP;
        SEL_STOP: phase <= SEL_IDLE;
        default:  phase <= SEL_IDLE;
      endcase
    end else if (tick16 && (phase != SEL_IDLE)) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign strb.loadShift = loadShift;
  assign strb.shiftData = segEnd && (phase == SEL_DATA);
  assign strb.sel       = phase;
  assign busy           = (phase != SEL_IDLE);

endmodule

// File: rtl/tx_datapath.sv
module tx_datapath
  import tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [6:0]        lineCtl,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           strb,
  output logic              holdFull,
  output fmt_t              fmt,
  output logic              txOut
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] charMask;
  logic [DATA_W-1:0] maskedHold;
  logic              parBit;
  logic              parReg;
  logic              lineBit;

  assign charMask   = {DATA_W{1'b1}} >> (2'd3 - lineCtl[1:0]);
  assign maskedHold = holdReg & charMask;
  assign parBit     = (^maskedHold) ^ ~lineCtl[4] ^ lineCtl[5];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      shiftReg <= '0;
      fmt      <= '0;
      parReg   <= 1'b0;
    end else begin
      if (wrEn) holdReg <= wrData;
      if (wrEn)                holdFull <= 1'b1;
      else if (strb.loadShift) holdFull <= 1'b0;
      if (strb.loadShift) begin
        shiftReg     <= maskedHold;
        fmt.lenCode  <= lineCtl[1:0];
        fmt.longStop <= lineCtl[2];
        fmt.parEn    <= lineCtl[3];
        parReg       <= parBit;
      end else if (strb.shiftData) begin
        shiftReg <= shiftReg >> 1;
      end
    end
  end

  always_comb begin
    unique case (strb.sel)
      SEL_START: lineBit = 1'b0;
      SEL_DATA:  lineBit = shiftReg[0];
      SEL_PAR:   lineBit = parReg;
      default:   lineBit = 1'b1;
    endcase
  end

  assign txOut = lineBit & ~lineCtl[6];

endmodule

// File: rtl/async_tx.sv
module async_tx
  import tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic [6:0]        lineCtl,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              txOut,
  output logic              holdEmpty,
  output logic              shiftEmpty
);

  strobe_t strb;
  fmt_t    fmt;
  logic    holdFull;
  logic    busy;

  tx_ctrl #(
    .DATA_W       (DATA_W),
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick16  (tick16),
    .holdFull(holdFull),
    .fmt     (fmt),
    .strb    (strb),
    .busy    (busy)
  );

  tx_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .lineCtl (lineCtl),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .strb    (strb),
    .holdFull(holdFull),
    .fmt     (fmt),
    .txOut   (txOut)
  );

  assign holdEmpty  = ~holdFull;
  assign shiftEmpty = ~busy;

endmodule

// File: rtl/tx_checker.sv
module tx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tick16,
  input logic [6:0] lineCtl,
  input logic       wrEn,
  input logic       txOut,
  input logic       holdEmpty,
  input logic       shiftEmpty
);

  a_r7_break_forces_space: assert property (@(posedge clk) disable iff (!rstN)
    lineCtl[6] |-> !txOut);

  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEmpty && !lineCtl[6]) |-> txOut);

  a_r8_write_fills_hold: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !holdEmpty);

  a_r8_empty_on_transfer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) |-> !shiftEmpty);

  a_r9_load_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftEmpty) |-> $past(!holdEmpty));

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftEmpty && !tick16) |=> ((txOut == $past(txOut)) || (lineCtl[6] != $past(lineCtl[6]))));

endmodule

bind async_tx tx_checker u_tx_checker (
  .clk       (clk),
  .rstN      (rstN),
  .tick16    (tick16),
  .lineCtl   (lineCtl),
  .wrEn      (wrEn),
  .txOut     (txOut),
  .holdEmpty (holdEmpty),
  .shiftEmpty(shiftEmpty)
);

// File: tb/test_async_tx.sv
module test_async_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic [6:0] lineCtl = 7'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic       txOut;
  logic       holdEmpty;
  logic       shiftEmpty;

  int    nChecks = 0;
  int    nErrors = 0;
  string curReq = "R1";
  int    tickPeriod = 3;
  int    tickPh = 0;

  async_tx i_async_tx (
    .clk       (clk),
    .rstN      (rstN),
    .tick16    (tick16),
    .lineCtl   (lineCtl),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .txOut     (txOut),
    .holdEmpty (holdEmpty),
    .shiftEmpty(shiftEmpty)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tickPh++;
    tick16 = ((tickPh % tickPeriod) == 0);
  end

  // behavioural reference: a queue of (level, tick count) segments per frame
  int   segLvl[$];
  int   segDur[$];
  bit   mBusy, mHoldFull;
  int   mLvl, mRemain;
  logic [7:0] mHold;

  task automatic buildFrame(input logic [7:0] d, input logic [6:0] lc);
    int nBits, ones, p, stopDur;
    segLvl.delete(); segDur.delete();
    nBits = 5 + lc[1:0];
    ones = 0;
    for (int i = 0; i < nBits; i++) begin
      segLvl.push_back(d[i]); segDur.push_back(16);
      ones += d[i];
    end
    if (lc[3]) begin
      p = lc[4] ? (ones % 2) : ((ones % 2) == 0);
      if (lc[5]) p = !p;
      segLvl.push_back(p); segDur.push_back(16);
    end
    if (!lc[2]) stopDur = 16;
    else if (lc[1:0] == 2'd0) stopDur = 24;
    else stopDur = 32;
    segLvl.push_back(1); segDur.push_back(stopDur);
    mLvl = 0; mRemain = 16; mBusy = 1;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mHoldFull = 0; mHold = 0; mLvl = 1; mRemain = 0;
      segLvl.delete(); segDur.delete();
    end else begin
      bit doLoad;
      doLoad = mHoldFull && (!mBusy || (tick16 && mRemain == 1 && segLvl.size() == 0));
      if (doLoad) begin
        buildFrame(mHold, lineCtl);
      end else if (mBusy && tick16) begin
        mRemain--;
        if (mRemain == 0) begin
          if (segLvl.size() == 0) mBusy = 0;
          else begin
            mLvl = segLvl.pop_front();
            mRemain = segDur.pop_front();
          end
        end
      end
      if (wrEn) begin mHold = wrData; mHoldFull = 1; end
      else if (doLoad) mHoldFull = 0;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rstN) begin
      check(curReq, "txOut", txOut, lineCtl[6] ? 0 : (mBusy ? mLvl : 1));
      check("R8", "holdEmpty", holdEmpty, !mHoldFull);
      check("R9", "shiftEmpty", shiftEmpty, !mBusy);
    end
  end

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk); wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (!(holdEmpty && shiftEmpty));
    repeat (3) @(negedge clk);
  endtask

  task automatic sendOne(input logic [6:0] lc, input logic [7:0] d);
    @(negedge clk); lineCtl = lc;
    writeByte(d);
    waitIdle();
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #5;
    check("R1", "reset txOut", txOut, 1);
    check("R1", "reset holdEmpty", holdEmpty, 1);
    check("R1", "reset shiftEmpty", shiftEmpty, 1);

    // R8 / R9 hand-off timing on an idle shifter
    curReq = "R9";
    @(negedge clk); lineCtl = 7'b0000011; wrData = 8'h96; wrEn = 1'b1;
    @(posedge clk); #5;
    check("R8", "holdEmpty after write", holdEmpty, 0);
    check("R9", "shiftEmpty before load", shiftEmpty, 1);
    @(negedge clk); wrEn = 1'b0;
    @(posedge clk); #5;
    check("R8", "holdEmpty after load", holdEmpty, 1);
    check("R9", "shiftEmpty after load", shiftEmpty, 0);
    waitIdle();

    curReq = "R2";
    for (int len = 0; len < 4; len++) begin
      sendOne({5'b00000, 2'(len)}, 8'hA5);
      sendOne({5'b00000, 2'(len)}, 8'h3C);
    end

    curReq = "R4";
    sendOne(7'b0000100, 8'h1F);
    sendOne(7'b0000110, 8'h55);
    sendOne(7'b0000101, 8'hE2);

    curReq = "R5";
    sendOne(7'b0110011, 8'hC3);
    sendOne(7'b0001011, 8'hC3);

    curReq = "R6";
    for (int s = 0; s < 4; s++) begin
      sendOne({1'b0, 1'(s >> 1), 1'(s), 1'b1, 1'b0, 2'b11}, 8'h5B);
      sendOne({1'b0, 1'(s >> 1), 1'(s), 1'b1, 1'b0, 2'b01}, 8'h2D);
    end

    curReq = "R10";
    @(negedge clk); lineCtl = 7'b0000011;
    writeByte(8'h81);
    writeByte(8'h7E);
    waitIdle();
    writeByte(8'h11);
    repeat (20) @(negedge clk);
    writeByte(8'h22);
    writeByte(8'h33);
    @(posedge clk); #5;
    check("R10", "pending after overwrite", holdEmpty, 0);
    waitIdle();

    curReq = "R11";
    @(negedge clk); lineCtl = 7'b0000011;
    writeByte(8'hF0);
    repeat (100) @(negedge clk);
    lineCtl = 7'b0011100;
    writeByte(8'h0F);
    waitIdle();

    curReq = "R7";
    @(negedge clk); lineCtl = 7'b0000011;
    writeByte(8'hFF);
    repeat (150) @(negedge clk);
    lineCtl[6] = 1'b1;
    @(posedge clk); #5;
    check("R7", "break mid-frame", txOut, 0);
    repeat (200) @(negedge clk);
    lineCtl[6] = 1'b0;
    waitIdle();
    @(negedge clk); lineCtl[6] = 1'b1;
    @(posedge clk); #5;
    check("R7", "break while idle", txOut, 0);
    @(negedge clk); lineCtl[6] = 1'b0;
    @(posedge clk); #5;
    check("R1", "idle after break", txOut, 1);

    curReq = "R3";
    tickPeriod = 1;
    sendOne(7'b0001111, 8'h6A);
    tickPeriod = 5;
    sendOne(7'b0011010, 8'h39);
    tickPeriod = 3;

    finishRun();
  end

endmodule